// File: doc/BRIEF.md
# Burst Byte-Lane Window Generator

This block walks through a burst one beat at a time. For each beat it reports the byte address and which byte lanes of a wide data bus that beat occupies. A burst is loaded from a start address, a transfer size (log2 of bytes per beat), a length field (beats minus one) and a burst kind. After that, every accepted beat advances the generator by one step. The lane mask can serve two purposes. On the write side it is the legal strobe window. On the read side it selects which lanes carry the returned data.

The lane of a byte is always its address modulo the bus width in bytes. There is no endian swapping. A narrow transfer therefore occupies a slice of the bus, and that slice moves with the address. An incrementing burst sweeps the slice across the bus. A wrapping burst sweeps it but folds back at the wrap boundary. A fixed burst keeps the slice in one place. An unaligned start clips the first beat so that it ends at the next size-aligned boundary.

Top module: `lane_steer`

## Requirements
- R1: While reset is held and after it is released, `active_o`, `last_o` and every bit of `mask_o` are low until a burst is loaded.
- R2: When `active_o` is low, `start_i` loads a burst, and on the next cycle `active_o` is high and `addr_o` equals `addr_i`. A `start_i` that arrives while a burst is running is ignored, and the running burst's addresses and masks do not change.
- R3: While active, bit n of `mask_o` is high exactly for the lanes n with (addr mod DATA_BYTES) <= n < A + 2^size. Here A is the address rounded down to a multiple of 2^size, taken mod DATA_BYTES. An unaligned first beat therefore enables only the lanes up to the next size-aligned boundary.
- R4: Incrementing burst (`burst_i` = 2'b01, and also the unused code 2'b11): the next beat address is the current address rounded down to 2^size, plus 2^size. For example, byte beats from 4 on an 8-lane bus use lanes 4,5,6,7,0, and 4-byte beats from 4 give masks 0xF0, 0x0F, 0xF0.
- R5: Fixed burst (`burst_i` = 2'b00): every beat repeats the start address and the same mask.
- R6: Wrapping burst (`burst_i` = 2'b10): addresses advance as in R4 but stay inside a window of (len+1)·2^size bytes that is aligned to its own size. After reaching the top of the window they return to its base.
- R7: A wrapping burst whose length field is not 1, 3, 7 or 15 (2, 4, 8 or 16 beats) behaves as an incrementing burst.
- R8: `last_o` is high exactly on the beat whose index (counting from 0) equals the length field. A step on that beat ends the burst, and `active_o` is low on the next cycle.
- R9: While `step_i` is low, a running burst holds its address, mask and last flag.
- R10: A size code larger than log2(DATA_BYTES) is treated as the full bus width: all lanes are enabled, and the address advances by DATA_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load a new burst (only when idle) |
| addr_i | input | ADDR_W | Start byte address |
| size_i | input | 3 | log2 of bytes per beat |
| len_i | input | LEN_W | Number of beats minus one |
| burst_i | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 incrementing |
| step_i | input | 1 | Current beat accepted; advance |
| active_o | output | 1 | A burst is in progress |
| addr_o | output | ADDR_W | Byte address of the current beat |
| mask_o | output | DATA_BYTES | Enabled byte lanes of the current beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
The hardest situation to reach from the ports is a new `start_i` that arrives while a burst is running, at a moment when the beat is not being stepped. The driver holds `step_i` low for several cycles mid-burst and pulses `start_i` with an unrelated address during that stall. The scoreboard then expects the original sequence to continue unchanged. The wrap fold-back also needs a start that sits in the upper part of its window, so the wrapping case begins at 0x38 inside a 16-byte window. The generator must then return to 0x30 after two beats.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'b00,
        BK_INCR  = 2'b01,
        BK_WRAP  = 2'b10
    } burst_kind_e;

endpackage

// File: rtl/lane_window.sv
module lane_window #(
    parameter int DATA_BYTES = 8,
    localparam int LANE_W = $clog2(DATA_BYTES)
) (
    input  logic [LANE_W-1:0]     lane_addr,
    input  logic [2:0]            size,
    output logic [DATA_BYTES-1:0] mask
);
    logic [LANE_W:0] lo_x;
    logic [LANE_W:0] nb;
    logic [LANE_W:0] base;
    logic [LANE_W:0] hi_x;

    always_comb begin
        lo_x = {1'b0, lane_addr};
        nb   = (LANE_W+1)'(1) << size;
        base = lo_x & ~(nb - (LANE_W+1)'(1));
        hi_x = base + nb;
    end

    for (genvar l = 0; l < DATA_BYTES; l++) begin : g_lane
        assign mask[l] = ((LANE_W+1)'(l) >= lo_x) && ((LANE_W+1)'(l) < hi_x);
    end
endmodule

// File: rtl/beat_addr_next.sv
module beat_addr_next
    import lane_steer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        size,
    input  logic [LEN_W-1:0]  len,
    input  burst_kind_e       kind,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] span_m1;

    always_comb begin
        inc     = ADDR_W'(1) << size;
        aligned = cur_addr & ~(inc - ADDR_W'(1));
        span_m1 = ((ADDR_W'(len) + ADDR_W'(1)) << size) - ADDR_W'(1);
        unique case (kind)
            BK_FIXED: nxt_addr = cur_addr;
            BK_WRAP:  nxt_addr = (cur_addr & ~span_m1) | ((aligned + inc) & span_m1);
            default:  nxt_addr = aligned + inc;
        endcase
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import lane_steer_pkg::*;
#(
    parameter int DATA_BYTES = 8,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [2:0]            size_i,
    input  logic [LEN_W-1:0]      len_i,
    input  logic [1:0]            burst_i,
    input  logic                  step_i,
    output logic                  active_o,
    output logic [ADDR_W-1:0]     addr_o,
    output logic [DATA_BYTES-1:0] mask_o,
    output logic                  last_o
);
    localparam int LANE_W   = $clog2(DATA_BYTES);
    localparam int MAX_SIZE = LANE_W;

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        size;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        burst_kind_e       kind;
    } steer_state_t;

    steer_state_t st_d, st_q;

    logic [2:0]            size_eff;
    logic                  wrap_len_ok;
    burst_kind_e           kind_in;
    logic [ADDR_W-1:0]     nxt_addr;
    logic [DATA_BYTES-1:0] mask_raw;
    logic                  at_last;

    always_comb begin
        size_eff    = (size_i > 3'(MAX_SIZE)) ? 3'(MAX_SIZE) : size_i;
        wrap_len_ok = (len_i == LEN_W'(1)) || (len_i == LEN_W'(3)) ||
                      (len_i == LEN_W'(7)) || (len_i == LEN_W'(15));
        unique case (burst_i)
            2'b00:   kind_in = BK_FIXED;
            2'b10:   kind_in = wrap_len_ok ? BK_WRAP : BK_INCR;
            default: kind_in = BK_INCR;
        endcase
    end

    beat_addr_next #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) u_next (
        .cur_addr(st_q.addr),
        .size    (st_q.size),
        .len     (st_q.len),
        .kind    (st_q.kind),
        .nxt_addr(nxt_addr)
    );

    lane_window #(
        .DATA_BYTES(DATA_BYTES)
    ) u_win (
        .lane_addr(st_q.addr[LANE_W-1:0]),
        .size     (st_q.size),
        .mask     (mask_raw)
    );

    assign at_last = st_q.cnt == st_q.len;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.addr   = addr_i;
                st_d.size   = size_eff;
                st_d.len    = len_i;
                st_d.cnt    = '0;
                st_d.kind   = kind_in;
            end
        end else if (step_i) begin
            if (at_last) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt  = st_q.cnt + LEN_W'(1);
                st_d.addr = nxt_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, addr: '0, size: '0, len: '0, cnt: '0, kind: BK_FIXED};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign addr_o   = st_q.addr;
    assign mask_o   = st_q.active ? mask_raw : '0;
    assign last_o   = st_q.active && at_last;
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
    parameter int DATA_BYTES = 8,
    parameter int ADDR_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic                  step_i,
    input logic                  active_o,
    input logic [ADDR_W-1:0]     addr_o,
    input logic [DATA_BYTES-1:0] mask_o,
    input logic                  last_o,
    input logic [2:0]            size_q,
    input logic [1:0]            kind_q
);
    logic [ADDR_W-1:0] low_bits;
    assign low_bits = (ADDR_W'(1) << size_q) - ADDR_W'(1);

    // R1: outputs quiet when idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (mask_o == '0) && !last_o);

    // R3: an active beat always enables at least one lane
    a_r3_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (mask_o != '0));

    // R10: never more lanes than the effective beat size
    a_r10_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> ($countones(mask_o) <= (1 << size_q)));

    // R8: stepping the last beat ends the burst
    a_r8_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && step_i && last_o |=> !active_o);

    // R9: no step holds the beat
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && !step_i |=> active_o && $stable(addr_o) && $stable(mask_o));

    // R2: start during a running burst is ignored
    a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && start_i && !step_i |=> $stable(addr_o));

    // R4: later beats of a moving burst are size-aligned
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && step_i && !last_o && (kind_q != 2'b00)
        |=> active_o && ((addr_o & low_bits) == '0));

    // R5: fixed burst keeps its address
    a_r5_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && step_i && !last_o && (kind_q == 2'b00) |=> $stable(addr_o));
endmodule

bind lane_steer lane_steer_chk #(
    .DATA_BYTES(DATA_BYTES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .step_i  (step_i),
    .active_o(active_o),
    .addr_o  (addr_o),
    .mask_o  (mask_o),
    .last_o  (last_o),
    .size_q  (st_q.size),
    .kind_q  (st_q.kind)
);

// File: tb/tb_lane_steer.sv
module tb_lane_steer;
    localparam int DB = 8;
    localparam int AW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [2:0]    size_i = '0;
    logic [LW-1:0] len_i = '0;
    logic [1:0]    burst_i = '0;
    logic          step_i = 1'b0;
    logic          active_o;
    logic [AW-1:0] addr_o;
    logic [DB-1:0] mask_o;
    logic          last_o;

    always #4 clk = ~clk;

    lane_steer #(.DATA_BYTES(DB), .ADDR_W(AW), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .size_i(size_i), .len_i(len_i), .burst_i(burst_i), .step_i(step_i),
        .active_o(active_o), .addr_o(addr_o), .mask_o(mask_o), .last_o(last_o)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [DB-1:0] m;
        logic          l;
    } exp_t;

    exp_t  q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 0;

    task automatic check(input string t, input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Expected beats from the requirements
    task automatic push_expect(input int addr, input int size, input int len, input int bk);
        int s, nb, a, lo, base, span;
        bit wrap;
        exp_t e;
        s    = (size > 3) ? 3 : size;
        nb   = 1 << s;
        wrap = (bk == 2) && (len == 1 || len == 3 || len == 7 || len == 15);
        span = (len + 1) * nb;
        a    = addr;
        for (int i = 0; i <= len; i++) begin
            lo   = a % DB;
            base = (a & ~(nb - 1)) % DB;
            e.a  = AW'(a);
            e.m  = '0;
            for (int b = 0; b < DB; b++) e.m[b] = (b >= lo) && (b < base + nb);
            e.l  = (i == len);
            q.push_back(e);
            if (bk == 0) a = a;
            else if (wrap) a = (a & ~(span - 1)) | (((a & ~(nb - 1)) + nb) & (span - 1));
            else a = (a & ~(nb - 1)) + nb;
        end
    endtask

    task automatic run(input string t, input int addr, input int size, input int len,
                       input int bk, input int stall, input bit inject);
        tag = t;
        @(negedge clk);
        push_expect(addr, size, len, bk);
        start_i = 1'b1; addr_i = AW'(addr); size_i = 3'(size);
        len_i = LW'(len); burst_i = 2'(bk);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i <= len; i++) begin
            for (int k = 0; k < stall; k++) begin
                step_i = 1'b0;
                if (inject && i == 1 && k == 0) begin
                    start_i = 1'b1; addr_i = 32'h0000_0F00; burst_i = 2'b01;
                end
                @(negedge clk);
                start_i = 1'b0;
            end
            step_i = 1'b1;
            @(negedge clk);
        end
        step_i = 1'b0;
        #2;
        check("R8", !active_o, "active after last step", 64'(active_o), 64'd0);
        check(t, q.size() == 0, "beats left in queue", 64'(q.size()), 64'd0);
        q.delete();
    endtask

    // Monitor: compare every active cycle against the queue head
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && active_o) begin
                if (q.size() == 0) begin
                    check("R2", 1'b0, "unexpected beat", 64'(addr_o), 64'd0);
                end else begin
                    e = q[0];
                    check(step_i ? tag : "R9", addr_o == e.a, "addr", 64'(addr_o), 64'(e.a));
                    check(step_i ? tag : "R9", mask_o == e.m, "mask", 64'(mask_o), 64'(e.m));
                    check("R8", last_o == e.l, "last", 64'(last_o), 64'(e.l));
                    if (step_i) void'(q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check("WDOG", 1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        #2;
        check("R1", !active_o && !last_o && mask_o == '0, "in reset", 64'({active_o, last_o, mask_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #2;
        check("R1", !active_o && !last_o && mask_o == '0, "after reset", 64'({active_o, last_o, mask_o}), 64'd0);

        run("R4", 32'h04, 0, 4, 1, 0, 0);   // byte beats: lanes 4,5,6,7,0
        run("R4", 32'h04, 2, 2, 1, 1, 0);   // 0xF0, 0x0F, 0xF0
        run("R3", 32'h13, 2, 2, 1, 0, 0);   // unaligned first beat
        run("R5", 32'h22, 1, 3, 0, 1, 0);   // fixed, lanes 2,3
        run("R6", 32'h38, 2, 3, 2, 0, 0);   // wrap 0x38,0x3C,0x30,0x34
        run("R6", 32'h05, 0, 7, 2, 0, 0);   // 8-beat byte wrap
        run("R7", 32'h08, 0, 2, 2, 0, 0);   // 3-beat wrap -> incr
        run("R4", 32'h40, 1, 2, 3, 0, 0);   // code 3 -> incr
        run("R10", 32'h10, 5, 2, 1, 0, 0);  // oversize clamps to bus
        run("R8", 32'h18, 3, 0, 1, 2, 0);   // single beat, full bus
        run("R2", 32'h60, 2, 3, 1, 3, 1);   // start during stall ignored
        run("R9", 32'h81, 0, 2, 1, 4, 0);   // long stalls

        finish_run();
    end
endmodule